// File: doc/BRIEF.md
# Write-Triggered DDR2 Command Issuer

This block turns ordinary bus writes into DDR2 control commands during memory bring-up. Software first writes a small code into a mode register. While that code is in force, a write into the memory window carries no data to memory. Instead it becomes exactly one DDR2 command on the command port. A nonzero code is not cleared by the write, so repeated writes repeat the command. This is how two refresh cycles are obtained from two writes.

The access address carries the command's operands. The bank field selects which mode register is loaded, so the same load-mode code reaches either the base mode register or extended mode register 1, depending on address bits 23:22. The row field supplies the operand bits. The geometry is a 16-bit device with 9 column bits, 12 row bits and 4 banks, so the row field occupies byte-address bits 21:10. When the code selects normal operation, a memory write is forwarded as a write strobe with its address and no command is issued.

Each access is acknowledged with a single-cycle pulse. The pulse comes only after any resulting command has been on the port for one clock.

Top module: `sdrcmd_issuer`

## Requirements
- R1: After reset, the command port is deselected (cs_n, ras_n, cas_n and we_n all 1, BA 0, A 0), bus_ack and mem_wr_o are 0, and the mode register reads 0.
- R2: A register write stores bus_wdata[2:0] in the mode register. A register read returns that value on bus_rdata by the time bus_ack is high. The value is kept unchanged through any number of memory accesses.
- R3: With mode code 0, 1, 6 or 7, a memory write issues no command. It pulses mem_wr_o for one cycle with mem_addr_o equal to bus_addr.
- R4: With mode code 2, a memory write issues all-banks precharge at any address: cs_n,ras_n,cas_n,we_n = 0,0,1,0, A = 0x400 (A10 set), BA = 0.
- R5: With mode code 3 or 5, a memory write issues a mode-register load: cs_n,ras_n,cas_n,we_n = 0,0,0,0, BA = bus_addr[23:22] (01 reaches extended register 1), A = {1'b0, bus_addr[21:10]}.
- R6: With mode code 4, every memory write, at any address, issues one auto-refresh: cs_n,ras_n,cas_n,we_n = 0,0,0,1, BA = 0, A = 0. Two writes give two refreshes.
- R7: An accepted request drives its command, or write strobe, for exactly one cycle, in the cycle after the accepting edge. bus_ack is high for exactly the next cycle and then returns low.
- R8: A memory read in any mode issues no command and no write strobe, and is still acknowledged.
- R9: In a command mode (2 to 5), mem_wr_o never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_is_reg | input | 1 | 1 = mode register, 0 = memory window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address within the memory window |
| bus_wdata | input | 3 | Mode code for register writes |
| bus_rdata | output | 3 | Mode register read data |
| bus_ack | output | 1 | Single-cycle completion pulse |
| mem_wr_o | output | 1 | Forwarded normal write strobe |
| mem_addr_o | output | 24 | Address of the forwarded write |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_a | output | 13 | Address operand |

## Verification
The bench sweeps every mode code against addresses in all four banks, with row patterns such as zero, all ones and alternating bits, and with varied column bits. A design that takes the bank field from the wrong position would send extended-register loads to the base register, and one that drops the zero-extension would leak a stray A12. The unused codes 1, 6 and 7 and memory reads are also swept, because a loose decode would turn them into spurious commands. Refresh and precharge are repeated at arbitrary addresses to catch a mode register that clears itself after use, and the ack cycle is checked to be exactly one cycle after the single-cycle command.

// File: rtl/sdrcmd_pkg.sv
package sdrcmd_pkg;

  localparam int MODE_W = 3;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_LOAD  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam pins_t PINS_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pins_t PINS_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_PRE  = 2'd1,
    K_LOAD = 2'd2,
    K_REF  = 2'd3
  } kind_t;

  function automatic kind_t kind_of(input logic [MODE_W-1:0] code);
    case (code)
      3'd2:       kind_of = K_PRE;
      3'd3, 3'd5: kind_of = K_LOAD;
      3'd4:       kind_of = K_REF;
      default:    kind_of = K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sdrcmd_mode_reg.sv
module sdrcmd_mode_reg
  import sdrcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= '0;
    else if (wr_en) mode_q <= wdata;
  end

  // R2: code only changes on an explicit register write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/sdrcmd_addr_split.sv
module sdrcmd_addr_split #(
  parameter int BYTE_SH = 1,
  parameter int COL_W   = 9,
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int A_W     = 13,
  localparam int ROW_LSB  = BYTE_SH + COL_W,
  localparam int BANK_LSB = ROW_LSB + ROW_W,
  localparam int ADDR_W   = BANK_LSB + BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [A_W-1:0]    row_op
);

  assign bank = addr[BANK_LSB +: BANK_W];

  generate
    if (A_W > ROW_W) begin : g_zext
      assign row_op = {{(A_W-ROW_W){1'b0}}, addr[ROW_LSB +: ROW_W]};
    end else begin : g_trunc
      assign row_op = addr[ROW_LSB +: A_W];
    end
  endgenerate

endmodule

// File: rtl/sdrcmd_seq.sv
module sdrcmd_seq
  import sdrcmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int A_W    = 13,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_reg,
  input  logic              wr,
  input  logic [MODE_W-1:0] mode,
  input  logic [BANK_W-1:0] bank,
  input  logic [A_W-1:0]    row_op,
  input  logic [ADDR_W-1:0] addr,
  output logic              accept,
  output logic              ack_q,
  output logic              mem_wr_q,
  output logic [ADDR_W-1:0] mem_addr_q,
  output pins_t             pins_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [A_W-1:0]    a_q
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_ACK} state_t;
  state_t state_q;

  localparam logic [A_W-1:0] A_ALLBANK = A_W'(1) << 10;

  kind_t kind;
  assign accept = (state_q == S_IDLE) && req;
  assign kind   = (!is_reg && wr) ? kind_of(mode) : K_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      ack_q      <= 1'b0;
      mem_wr_q   <= 1'b0;
      mem_addr_q <= '0;
      pins_q     <= PINS_DESEL;
      ba_q       <= '0;
      a_q        <= '0;
    end else begin
      pins_q   <= PINS_DESEL;
      ba_q     <= '0;
      a_q      <= '0;
      mem_wr_q <= 1'b0;
      ack_q    <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_ISSUE;
          case (kind)
            K_PRE:  begin pins_q <= PINS_PRE;  a_q <= A_ALLBANK; end
            K_LOAD: begin pins_q <= PINS_LOAD; ba_q <= bank; a_q <= row_op; end
            K_REF:  pins_q <= PINS_REF;
            default: if (!is_reg && wr) begin
              mem_wr_q   <= 1'b1;
              mem_addr_q <= addr;
            end
          endcase
        end
        S_ISSUE: begin
          state_q <= S_ACK;
          ack_q   <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R7: a command occupies the port for a single cycle
  p_cmd_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    !pins_q.cs_n |=> pins_q.cs_n);
  // R7: acknowledge follows the command cycle directly
  p_ack_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    !pins_q.cs_n |=> ack_q);
  // R7: acknowledge is a one-cycle pulse
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);
  // R9: a forwarded write and a command never coincide
  p_no_mix_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_q && !pins_q.cs_n));
  // R4: precharge always targets all banks
  p_pre_allbank_r4: assert property (@(posedge clk) disable iff (rst)
    (!pins_q.cs_n && !pins_q.ras_n && pins_q.cas_n && !pins_q.we_n) |-> a_q[10]);

endmodule

// File: rtl/sdrcmd_issuer.sv
module sdrcmd_issuer
  import sdrcmd_pkg::*;
#(
  parameter int BYTE_SH = 1,
  parameter int COL_W   = 9,
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int A_W     = 13,
  localparam int ADDR_W = BYTE_SH + COL_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_is_reg,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MODE_W-1:0] bus_wdata,
  output logic [MODE_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [A_W-1:0]    cmd_a
);

  logic              accept;
  logic [MODE_W-1:0] mode;
  logic [BANK_W-1:0] bank;
  logic [A_W-1:0]    row_op;
  pins_t             pins;

  sdrcmd_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (accept && bus_is_reg && bus_wr),
    .wdata  (bus_wdata),
    .mode_q (mode)
  );

  sdrcmd_addr_split #(
    .BYTE_SH (BYTE_SH),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W),
    .BANK_W  (BANK_W),
    .A_W     (A_W)
  ) u_split (
    .addr   (bus_addr),
    .bank   (bank),
    .row_op (row_op)
  );

  sdrcmd_seq #(
    .BANK_W (BANK_W),
    .A_W    (A_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (bus_req),
    .is_reg     (bus_is_reg),
    .wr         (bus_wr),
    .mode       (mode),
    .bank       (bank),
    .row_op     (row_op),
    .addr       (bus_addr),
    .accept     (accept),
    .ack_q      (bus_ack),
    .mem_wr_q   (mem_wr_o),
    .mem_addr_q (mem_addr_o),
    .pins_q     (pins),
    .ba_q       (cmd_ba),
    .a_q        (cmd_a)
  );

  always_ff @(posedge clk) begin
    if (rst)                               bus_rdata <= '0;
    else if (accept && bus_is_reg && !bus_wr) bus_rdata <= mode;
  end

  assign cmd_cs_n  = pins.cs_n;
  assign cmd_ras_n = pins.ras_n;
  assign cmd_cas_n = pins.cas_n;
  assign cmd_we_n  = pins.we_n;

endmodule

// File: tb/sdrcmd_issuer_tb_top.sv
`timescale 1ns/1ps
module sdrcmd_issuer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_is_reg = 1'b0, bus_wr = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [2:0]  bus_wdata = '0;
  logic [2:0]  bus_rdata;
  logic        bus_ack, mem_wr_o;
  logic [23:0] mem_addr_o;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] a;

  int vecs = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdrcmd_issuer dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_is_reg(bus_is_reg),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(ba), .cmd_a(a)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pinv();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // One access; expected command pins/ba/a, expected strobe, expected rdata (reads of reg)
  task automatic access(input bit is_reg, input bit wr, input logic [23:0] adr,
                        input logic [2:0] wd, input logic [3:0] e_pins,
                        input logic [1:0] e_ba, input logic [12:0] e_a,
                        input bit e_wr, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_is_reg = is_reg; bus_wr = wr; bus_addr = adr; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    chk(pinv() == e_pins, tag, 32'(pinv()), 32'(e_pins));
    chk(ba == e_ba && a == e_a, tag, {17'h0, ba, a}, {17'h0, e_ba, e_a});
    chk(mem_wr_o == e_wr, tag, 32'(mem_wr_o), 32'(e_wr));
    if (e_wr) chk(mem_addr_o == adr, "R3 addr", 32'(mem_addr_o), 32'(adr));
    chk(bus_ack == 1'b0, "R7 early ack", 32'(bus_ack), 0);
    @(posedge clk);
    @(negedge clk);
    chk(bus_ack == 1'b1, "R7 ack", 32'(bus_ack), 1);
    chk(pinv() == 4'hF && !mem_wr_o, "R7 one-cycle cmd", 32'({mem_wr_o, pinv()}), 32'hF);
    bus_req = 1'b0;
    @(posedge clk);
    #1;
    chk(bus_ack == 1'b0, "R7 ack pulse", 32'(bus_ack), 0);
  endtask

  task automatic read_mode(input logic [2:0] exp, input string tag);
    access(1'b1, 1'b0, 24'h0, 3'h0, 4'hF, 2'd0, 13'd0, 1'b0, tag);
    chk(bus_rdata == exp, tag, 32'(bus_rdata), 32'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] rows [6];
    rows[0] = 12'h000; rows[1] = 12'hFFF; rows[2] = 12'h555;
    rows[3] = 12'hAAA; rows[4] = 12'h001; rows[5] = 12'h800;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(pinv() == 4'hF && ba == 0 && a == 0, "R1 pins", 32'(pinv()), 32'hF);
    chk(!bus_ack && !mem_wr_o, "R1 ack/strobe", 32'({bus_ack, mem_wr_o}), 0);
    read_mode(3'd0, "R1 mode");

    for (int m = 0; m < 8; m++) begin
      access(1'b1, 1'b1, 24'h0, 3'(m), 4'hF, 2'd0, 13'd0, 1'b0, "R2 write");
      read_mode(3'(m), "R2 readback");
      for (int b = 0; b < 4; b++) begin
        for (int r = 0; r < 6; r++) begin
          logic [23:0] adr;
          logic [3:0]  ep;
          logic [1:0]  eb;
          logic [12:0] ea;
          bit          ew;
          string       tg;
          adr = {2'(b), rows[r], 10'((r * 133 + b * 37) & 10'h3FF)};
          ep = 4'hF; eb = 0; ea = 0; ew = 1'b0;
          case (m)
            2: begin ep = 4'b0010; ea = 13'h400; tg = "R4 precharge"; end
            3, 5: begin ep = 4'b0000; eb = 2'(b); ea = {1'b0, rows[r]}; tg = "R5 load mode"; end
            4: begin ep = 4'b0001; tg = "R6 refresh"; end
            default: begin ew = 1'b1; tg = "R3 normal"; end
          endcase
          access(1'b0, 1'b1, adr, 3'h0, ep, eb, ea, ew, tg);
          if (m >= 2 && m <= 5) chk(!ew, "R9 no strobe", 0, 0);
        end
        // R8 memory read: nothing issued
        access(1'b0, 1'b0, {2'(b), 22'h12345}, 3'h0, 4'hF, 2'd0, 13'd0, 1'b0, "R8 read");
      end
      read_mode(3'(m), "R2 held");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule